// File: doc/BRIEF.md
# Set-Associative Translation Buffer Command Engine

This block holds the main address-translation buffer of a processor memory unit, organised as sets and ways, and serves it through three software-visible registers and a command port. Software loads a first descriptor (virtual page number, flag bits, address-space ID), a second descriptor (frame address and permissions, stored as an opaque word) and an index register. It then issues one of four commands. The commands look up an entry, pick a slot for a new entry, store an entry or fetch one back. Results return in the index register and the two descriptor registers. Lookup, slot choice and storing are separate commands that share the index register. A lookup that hits more than one way reports a duplicate error and does not resolve it.

Whenever an entry is stored, the engine raises a one-cycle notice for the front-end micro-buffers. A small state machine sequences every command. It has three states. ST_IDLE accepts register writes and commands. ST_EXEC performs the command on the selected set or entry. ST_DONE raises the completion pulse. It has three transitions: ST_IDLE to ST_EXEC on an accepted command, ST_EXEC to ST_DONE always, and ST_DONE to ST_IDLE always.

Descriptor layout: bits [31:13] are the virtual page number; bits [19:13] (its low seven bits) select the set; bit 8 is the present bit; bits [12:9] are other flags; bits [7:0] are the address-space ID. Index register layout: bit 31 is the lookup-error flag; bits [8:0] hold the linear index (default geometry of 128 sets by 4 ways). Commands on `cmd_op`: 0 probe, 1 get-index, 2 write, 3 read. Register selects on `sw_wr_sel`: 0 first descriptor, 1 second descriptor, 2 index.

Top module: `tlb_engine`

## Requirements
- R1: After reset, all three registers read zero, busy and done are low, and every entry is invalid.
- R2: An entry's linear index is set × WAYS + way, and the set is taken from descriptor bits [19:13].
- R3: A probe compares page number [31:13] and ID [7:0] against the valid ways of the set and ignores flag bits [12:9]. On exactly one hit it loads that way's linear index and clears bit 31.
- R4: A probe with no hit sets bit 31 and clears the index bits.
- R5: A probe that hits two or more ways sets bit 31 and bit 0, with all other index bits zero.
- R6: Get-index loads the linear index of the lowest invalid way of the set and clears bit 31. When all ways are valid it uses a per-set rotating pointer, which advances by one each time it is used.
- R7: A write stores both descriptors into the entry named by the index. Bit 8 marks the entry valid, and all-zero descriptors erase it. `utlb_flush` pulses together with done for writes only.
- R8: A read loads both descriptors from the entry named by the index and leaves the index unchanged.
- R9: done pulses for one cycle exactly two cycles after the command is accepted. busy stays high from acceptance through that pulse.
- R10: Commands and register writes presented while busy is high have no effect.
- R11: A software write to the index register stores the low 9 data bits and clears the lookup-error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr_en | input | 1 | Register write strobe |
| sw_wr_sel | input | 2 | Register select: 0 desc0, 1 desc1, 2 index |
| sw_wr_data | input | 32 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command: 0 probe, 1 get-index, 2 write, 3 read |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| utlb_flush | output | 1 | Pulse telling micro-buffers an entry was written |
| pd0_out | output | 32 | First descriptor register |
| pd1_out | output | 32 | Second descriptor register |
| index_out | output | 32 | Index register with error flag in bit 31 |

## Verification
The assertions check the timing skeleton on every cycle. They cover the fixed two-cycle latency and single done pulse, the flush pulse that follows every accepted write, and the rule that the error flag rises only when a command completes. They also check that the registers hold still while idle with no write and after done, and that a software index write clears the error. Only the bench scenarios can show the data results. These include hit, miss and duplicate probe codes, the choice between an invalid way and the rotating pointer, and the read-back of stored descriptors. The bench also shows that a command or register write arriving mid-command leaves no trace.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int DW = 32;

    typedef enum logic [1:0] {
        OP_PROBE  = 2'd0,
        OP_GETIDX = 2'd1,
        OP_WRITE  = 2'd2,
        OP_READ   = 2'd3
    } tlb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_DONE = 2'd2
    } tlb_state_e;

    localparam logic [1:0] SEL_PD0 = 2'd0;
    localparam logic [1:0] SEL_PD1 = 2'd1;
    localparam logic [1:0] SEL_IDX = 2'd2;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
    parameter int SETS        = 128,
    parameter int WAYS        = 4,
    parameter int PAGE_SHIFT  = 13,
    parameter int ASID_W      = 8,
    parameter int PRESENT_BIT = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [$clog2(SETS*WAYS)-1:0]     idx,
    input  logic [31:0]                      wr_pd0,
    input  logic [31:0]                      wr_pd1,
    output logic [31:0]                      rd_pd0,
    output logic [31:0]                      rd_pd1,
    input  logic [$clog2(SETS)-1:0]          set_sel,
    output logic [WAYS-1:0]                  set_valid,
    output logic [WAYS*(32-PAGE_SHIFT+ASID_W)-1:0] set_tags
);
    localparam int ENTRIES = SETS * WAYS;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int TAG_W   = 32 - PAGE_SHIFT + ASID_W;

    logic [31:0] mem_pd0 [ENTRIES];
    logic [31:0] mem_pd1 [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                mem_pd0[e] <= '0;
                mem_pd1[e] <= '0;
            end
        end else if (wr_en) begin
            mem_pd0[idx] <= wr_pd0;
            mem_pd1[idx] <= wr_pd1;
        end
    end

    assign rd_pd0 = mem_pd0[idx];
    assign rd_pd1 = mem_pd1[idx];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [31:0] ent;
        assign ent          = mem_pd0[{set_sel, WAY_W'(w)}];
        assign set_valid[w] = ent[PRESENT_BIT];
        assign set_tags[w*TAG_W +: TAG_W] = {ent[31:PAGE_SHIFT], ent[ASID_W-1:0]};
    end
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 27
) (
    input  logic [WAYS-1:0]       set_valid,
    input  logic [WAYS*TAG_W-1:0] set_tags,
    input  logic [TAG_W-1:0]      key_tag,
    output logic                  hit,
    output logic                  dup,
    output logic [$clog2(WAYS)-1:0] hit_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W:0] cnt;

    always_comb begin
        cnt     = '0;
        hit_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (set_valid[w] && set_tags[w*TAG_W +: TAG_W] == key_tag) begin
                cnt     = cnt + 1'b1;
                hit_way = WAY_W'(w);
            end
        end
        hit = (cnt == 1);
        dup = (cnt > 1);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int SETS = 128,
    parameter int WAYS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(SETS)-1:0]    set_sel,
    input  logic [WAYS-1:0]            set_valid,
    input  logic                       advance,
    output logic [$clog2(WAYS)-1:0]    vic_way
);
    localparam int WAY_W = $clog2(WAYS);

    logic [WAY_W-1:0] rr_q [SETS];
    logic             full;

    assign full = &set_valid;

    always_comb begin
        vic_way = rr_q[set_sel];
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!set_valid[w]) vic_way = WAY_W'(w);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (advance && full) begin
            rr_q[set_sel] <= rr_q[set_sel] + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_engine.sv
module tlb_engine
    import tlb_pkg::*;
#(
    parameter int SETS        = 128,
    parameter int WAYS        = 4,
    parameter int PAGE_SHIFT  = 13,
    parameter int ASID_W      = 8,
    parameter int PRESENT_BIT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_wr_en,
    input  logic [1:0]  sw_wr_sel,
    input  logic [31:0] sw_wr_data,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    output logic        busy,
    output logic        done,
    output logic        utlb_flush,
    output logic [31:0] pd0_out,
    output logic [31:0] pd1_out,
    output logic [31:0] index_out
);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int IDXW  = SET_W + WAY_W;
    localparam int TAG_W = 32 - PAGE_SHIFT + ASID_W;

    tlb_state_e       state_q, state_d;
    tlb_op_e          op_q;
    logic [31:0]      pd0_q, pd1_q;
    logic             idx_err;
    logic [IDXW-1:0]  idx_val;

    logic [SET_W-1:0]      set_sel;
    logic [WAYS-1:0]       set_valid;
    logic [WAYS*TAG_W-1:0] set_tags;
    logic [31:0]           rd_pd0, rd_pd1;
    logic                  hit, dup;
    logic [WAY_W-1:0]      hit_way, vic_way;
    logic                  exec;

    assign set_sel = pd0_q[PAGE_SHIFT +: SET_W];
    assign exec    = (state_q == ST_EXEC);

    tlb_store #(
        .SETS(SETS), .WAYS(WAYS), .PAGE_SHIFT(PAGE_SHIFT),
        .ASID_W(ASID_W), .PRESENT_BIT(PRESENT_BIT)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(exec && op_q == OP_WRITE),
        .idx(idx_val), .wr_pd0(pd0_q), .wr_pd1(pd1_q),
        .rd_pd0(rd_pd0), .rd_pd1(rd_pd1),
        .set_sel(set_sel), .set_valid(set_valid), .set_tags(set_tags)
    );

    tlb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .set_valid(set_valid), .set_tags(set_tags),
        .key_tag({pd0_q[31:PAGE_SHIFT], pd0_q[ASID_W-1:0]}),
        .hit(hit), .dup(dup), .hit_way(hit_way)
    );

    tlb_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
        .clk(clk), .rst_n(rst_n), .set_sel(set_sel), .set_valid(set_valid),
        .advance(exec && op_q == OP_GETIDX), .vic_way(vic_way)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid) state_d = ST_EXEC;
            ST_EXEC: state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Registers and command results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_PROBE;
            pd0_q   <= '0;
            pd1_q   <= '0;
            idx_err <= 1'b0;
            idx_val <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_valid) op_q <= tlb_op_e'(cmd_op);
                    if (sw_wr_en) begin
                        if (sw_wr_sel == SEL_PD0) pd0_q <= sw_wr_data;
                        if (sw_wr_sel == SEL_PD1) pd1_q <= sw_wr_data;
                        if (sw_wr_sel == SEL_IDX) begin
                            idx_val <= sw_wr_data[IDXW-1:0];
                            idx_err <= 1'b0;
                        end
                    end
                end
                ST_EXEC: begin
                    unique case (op_q)
                        OP_PROBE: begin
                            if (hit) begin
                                idx_err <= 1'b0;
                                idx_val <= {set_sel, hit_way};
                            end else if (dup) begin
                                idx_err <= 1'b1;
                                idx_val <= IDXW'(1);
                            end else begin
                                idx_err <= 1'b1;
                                idx_val <= '0;
                            end
                        end
                        OP_GETIDX: begin
                            idx_err <= 1'b0;
                            idx_val <= {set_sel, vic_way};
                        end
                        OP_READ: begin
                            pd0_q <= rd_pd0;
                            pd1_q <= rd_pd1;
                        end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_DONE);
        utlb_flush = done && (op_q == OP_WRITE);
        pd0_out    = pd0_q;
        pd1_out    = pd1_q;
        index_out  = {idx_err, {(31-IDXW){1'b0}}, idx_val};
    end
endmodule

// File: rtl/tlb_engine_chk.sv
module tlb_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        sw_wr_en,
    input logic [1:0]  sw_wr_sel,
    input logic        cmd_valid,
    input logic [1:0]  cmd_op,
    input logic        busy,
    input logic        done,
    input logic        utlb_flush,
    input logic [31:0] pd0_out,
    input logic [31:0] pd1_out,
    input logic [31:0] index_out
);
    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> ##1 done); // R9
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9
    AST_FLUSH_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'd2) |=> ##1 utlb_flush); // R7
    AST_ERR_ON_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(index_out[31]) |-> done); // R4
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !sw_wr_en) |=> ($stable(pd0_out) && $stable(pd1_out) && $stable(index_out))); // R10
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ($stable(pd0_out) && $stable(pd1_out) && $stable(index_out))); // R10
    AST_SW_IDX_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && !busy && sw_wr_sel == 2'd2) |=> !index_out[31]); // R11
endmodule

bind tlb_engine tlb_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .busy(busy), .done(done),
    .utlb_flush(utlb_flush), .pd0_out(pd0_out), .pd1_out(pd1_out),
    .index_out(index_out)
);

// File: tb/tlb_engine_bench.sv
module tlb_engine_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  op;
        logic        use_idx;
        logic        chk_pd;
        logic [31:0] pd0;
        logic [31:0] pd1;
        logic [31:0] idx;
        logic [31:0] exp_idx;
        logic [31:0] exp_pd0;
        logic [31:0] exp_pd1;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 1'b0, 1'b0, 32'h0000_2105, 32'h0,          32'h0, 32'h0000_0004, 32'h0, 32'h0},
        '{2'd2, 1'b0, 1'b0, 32'h0000_2105, 32'hAAAA_0001,  32'h0, 32'h0000_0004, 32'h0, 32'h0},
        '{2'd0, 1'b0, 1'b0, 32'h0000_2105, 32'hAAAA_0001,  32'h0, 32'h0000_0004, 32'h0, 32'h0},
        '{2'd0, 1'b0, 1'b0, 32'h0000_2106, 32'h0,          32'h0, 32'h8000_0000, 32'h0, 32'h0},
        '{2'd1, 1'b0, 1'b0, 32'h0000_2106, 32'h0,          32'h0, 32'h0000_0005, 32'h0, 32'h0},
        '{2'd2, 1'b0, 1'b0, 32'h0000_2106, 32'hBBBB_0002,  32'h0, 32'h0000_0005, 32'h0, 32'h0},
        '{2'd3, 1'b1, 1'b1, 32'h0,         32'h0,          32'h4, 32'h0000_0004, 32'h0000_2105, 32'hAAAA_0001},
        '{2'd2, 1'b1, 1'b0, 32'h0000_2105, 32'hCCCC_0003,  32'h6, 32'h0000_0006, 32'h0, 32'h0},
        '{2'd0, 1'b0, 1'b0, 32'h0000_2105, 32'h0,          32'h0, 32'h8000_0001, 32'h0, 32'h0},
        '{2'd2, 1'b1, 1'b0, 32'h0,         32'h0,          32'h6, 32'h0000_0006, 32'h0, 32'h0},
        '{2'd0, 1'b0, 1'b0, 32'h0000_2105, 32'h0,          32'h0, 32'h0000_0004, 32'h0, 32'h0},
        '{2'd0, 1'b0, 1'b0, 32'h0000_4105, 32'h0,          32'h0, 32'h8000_0000, 32'h0, 32'h0},
        '{2'd0, 1'b0, 1'b0, 32'h0000_2F05, 32'h0,          32'h0, 32'h0000_0004, 32'h0, 32'h0},
        '{2'd3, 1'b1, 1'b1, 32'h0,         32'h0,          32'h5, 32'h0000_0005, 32'h0000_2106, 32'hBBBB_0002}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_wr_en = 1'b0;
    logic [1:0]  sw_wr_sel = 2'd0;
    logic [31:0] sw_wr_data = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        busy, done, utlb_flush;
    logic [31:0] pd0_out, pd1_out, index_out;

    int n_tests = 0;
    int n_fail  = 0;
    logic flush_seen;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_engine u_tlb_engine (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel),
        .sw_wr_data(sw_wr_data), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .busy(busy), .done(done), .utlb_flush(utlb_flush),
        .pd0_out(pd0_out), .pd1_out(pd1_out), .index_out(index_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_sel = sel; sw_wr_data = data;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic issue(input logic [1:0] op);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 busy in exec", {31'd0, busy}, 32'd1);
        check("R9 no early done", {31'd0, done}, 32'd0);
        @(negedge clk);
        check("R9 done at two cycles", {31'd0, done}, 32'd1);
        flush_seen = utlb_flush;
    endtask

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'd0:    return "R3 R4 R5 probe";
            2'd1:    return "R2 R6 get-index";
            2'd2:    return "R7 write";
            default: return "R8 read";
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 index", index_out, 32'h0);
        check("R1 pd0", pd0_out, 32'h0);
        check("R1 pd1", pd1_out, 32'h0);
        check("R1 busy/done", {30'd0, busy, done}, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            sw_write(2'd0, VECS[i].pd0);
            sw_write(2'd1, VECS[i].pd1);
            if (VECS[i].use_idx) sw_write(2'd2, VECS[i].idx);
            issue(VECS[i].op);
            check(op_tag(VECS[i].op), index_out, VECS[i].exp_idx);
            check("R7 flush only on write", {31'd0, flush_seen},
                  {31'd0, VECS[i].op == 2'd2});
            if (VECS[i].chk_pd) begin
                check("R8 read pd0", pd0_out, VECS[i].exp_pd0);
                check("R8 read pd1", pd1_out, VECS[i].exp_pd1);
            end
        end

        // R11: direct index write clears the error left by the last miss probe
        sw_write(2'd0, 32'h0000_4105);
        issue(2'd0);
        check("R4 miss before sw write", index_out, 32'h8000_0000);
        sw_write(2'd2, 32'hFFFF_FE07);
        check("R11 sw index write", index_out, 32'h0000_0007);

        // R6: fill set 3, then rotating victim, then invalid way preferred
        for (int k = 0; k < 4; k++) begin
            sw_write(2'd0, 32'h0000_6100 | k);
            sw_write(2'd1, 32'h1000_0000 | k);
            issue(2'd1);
            check("R6 fill lowest invalid", index_out, 32'd12 + k);
            issue(2'd2);
        end
        sw_write(2'd0, 32'h0000_6109);
        issue(2'd1);
        check("R6 rotating victim first", index_out, 32'd12);
        issue(2'd1);
        check("R6 rotating victim advances", index_out, 32'd13);
        sw_write(2'd0, 32'h0);
        sw_write(2'd1, 32'h0);
        sw_write(2'd2, 32'd14);
        issue(2'd2);
        check("R7 erase write flush", {31'd0, flush_seen}, 32'd1);
        sw_write(2'd0, 32'h0000_6109);
        issue(2'd1);
        check("R6 erased way preferred", index_out, 32'd14);

        // R10: command and register write during busy are ignored
        sw_write(2'd0, 32'h0000_A100);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1;
        @(negedge clk);
        cmd_op = 2'd2;
        sw_wr_en = 1'b1; sw_wr_sel = 2'd2; sw_wr_data = 32'h0000_01FF;
        @(negedge clk);
        cmd_valid = 1'b0; sw_wr_en = 1'b0;
        check("R10 done of first command", {31'd0, done}, 32'd1);
        check("R10 no flush from ignored write", {31'd0, utlb_flush}, 32'd0);
        check("R10 index from get-index", index_out, 32'd20);
        @(negedge clk);
        check("R10 no second command", {30'd0, busy, done}, 32'd0);
        check("R10 index kept", index_out, 32'd20);
        sw_write(2'd0, 32'h0000_A100);
        issue(2'd0);
        check("R10 entry not written", index_out, 32'h8000_0000);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule